// File: doc/BRIEF.md
# Console Serial Port with Interrupt Request

This block is a reduced console port that sits on a simple processor bus with select, read and write strobes. It exposes two byte registers: a status register (written as a control register) and a data register. Incoming characters arrive on a valid/data input and are held in a one-entry buffer. Outgoing characters leave on a valid/data output one cycle after the bus write. Baud generation, framing and line serialisation live elsewhere.

The port raises an interrupt request toward a priority interrupt controller. A receive interrupt fires once per held character when the receive enable is set. A transmit interrupt fires on every data write when the transmit enable field selects it: the request drops for one cycle and then comes back. When the controller acknowledges at this port's level, the port answers that the autovector should be used.

Top module: `console_uart`

## Requirements
- R1: After reset the status register reads 0x02, the control register is 0x00, the interrupt request is low and no output character is valid.
- R2: A read at byte address 0 returns the status: bit 0 receive full, bit 1 transmitter empty (always 1), bit 7 receive interrupt pending, bits 6..2 zero. A write at address 0 loads the control register and leaves the status unchanged.
- R3: A character presented with the input valid strobe at a clock edge is stored when the buffer is empty, and status bit 0 reads 1 from that edge on.
- R4: With control bit 7 set and a character held, the interrupt request and status bit 7 rise on the edge after status bit 0 is set, and are raised only once per character.
- R5: A read at byte address 2 while a character is held returns that character; at that edge status bits 0 and 7 clear and the interrupt request drops.
- R6: A read at address 2 with the buffer empty returns 0xFF, leaves the status unchanged and drops the interrupt request.
- R7: A character that arrives while the buffer is full is dropped and the held character is kept.
- R8: A write at address 2 places the written byte on the output with its valid strobe high for exactly one cycle, starting at the edge of the write.
- R9: When control bits [6:5] equal 2'b01, a data write drives the interrupt request low at the write edge and high again one edge later; other values of [6:5] raise no request on a write.
- R10: The autovector answer is high exactly while an acknowledge is presented with a level equal to the port's level parameter (default 5).
- R11: With control bit 7 clear, a held character leaves status bit 7 and the interrupt request low.
- R12: Accesses at byte addresses 1 and 3 change no state and emit no character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Port select |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Byte address within the port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid during the read cycle |
| char_in_vld | input | 1 | Incoming character valid |
| char_in | input | 8 | Incoming character |
| char_out_vld | output | 1 | Outgoing character valid, one cycle |
| char_out | output | 8 | Outgoing character |
| irq_req | output | 1 | Interrupt request to the controller |
| ack_valid | input | 1 | Interrupt acknowledge cycle |
| ack_level | input | LVL_W | Level being acknowledged |
| ack_autovec | output | 1 | Autovector answer for this port |

## Verification
A wrong buffer-full or pending flag shows on the very next status read, and a stuck pending flag shows as a missing interrupt for the next character within two cycles of its arrival. A lost or mistimed transmit kick shows on the interrupt request within two cycles of a data write. A corrupted held character or a wrongly accepted overflow character shows on the first data read after it.

// File: rtl/cons_pkg.sv
// Shared constants and types for the console port.
// Assumes an 8-bit data path and byte addresses 0 (status/control) and 2 (data).
package cons_pkg;
    localparam int DATA_W   = 8;
    localparam int ST_RXF   = 0;
    localparam int ST_TXE   = 1;
    localparam int ST_PEND  = 7;
    localparam int CTL_RXIE = 7;
    localparam int CTL_TX_HI = 6;
    localparam int CTL_TX_LO = 5;
    localparam logic [1:0] TXIE_CODE = 2'b01;
    localparam int OFS_STAT = 0;
    localparam int OFS_DATA = 2;

    typedef struct packed {
        logic stat_rd;
        logic data_rd;
        logic ctl_wr;
        logic data_wr;
    } cons_acc_t;
endpackage

// File: rtl/cons_bus_dec.sv
// Bus access decoder: turns select, strobes and address into one-hot access kinds.
// Assumes only offsets 0 and 2 are mapped; all other offsets decode to nothing.
module cons_bus_dec
    import cons_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic              sel,
    input  logic              rd,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output cons_acc_t         acc
);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);

    // Decode the access kind for this cycle.
    always_comb begin
        acc.stat_rd = sel && rd && (addr == A_STAT);
        acc.data_rd = sel && rd && (addr == A_DATA);
        acc.ctl_wr  = sel && wr && (addr == A_STAT);
        acc.data_wr = sel && wr && (addr == A_DATA);
    end
endmodule

// File: rtl/cons_rx_buf.sv
// One-entry receive buffer. Captures a character when empty, drops it when full,
// and empties when the data register is read. Assumes synchronous active-low reset.
module cons_rx_buf #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_vld,
    input  logic [DW-1:0] in_data,
    input  logic          take,
    output logic          full,
    output logic [DW-1:0] held
);
    // Track occupancy: fill on arrival into an empty slot, empty on a data read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
        end else if (take) begin
            full <= 1'b0;
        end else if (in_vld) begin
            full <= 1'b1;
        end
    end

    // Hold the character; a new one is accepted only into an empty slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= '0;
        end else if (in_vld && !full && !take) begin
            held <= in_data;
        end
    end
endmodule

// File: rtl/cons_irq_ctl.sv
// Interrupt request logic. Raises once per held character when receive interrupts
// are enabled, drops on any data read, and on a data write with transmit interrupts
// enabled drops the request for one cycle before raising it again.
module cons_irq_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic full,
    input  logic rxie,
    input  logic txie,
    input  logic data_rd,
    input  logic data_wr,
    output logic irq,
    output logic pend,
    output logic kick
);
    logic raise;

    // A receive interrupt is due when a character waits and none is yet pending.
    always_comb raise = full && rxie && !pend;

    // Sequence the request, the pending flag and the transmit re-raise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq  <= 1'b0;
            pend <= 1'b0;
            kick <= 1'b0;
        end else begin
            kick <= 1'b0;
            if (data_rd) begin
                irq  <= 1'b0;
                pend <= 1'b0;
            end else begin
                if (data_wr && txie) begin
                    irq  <= 1'b0;
                    kick <= 1'b1;
                end else if (kick || raise) begin
                    irq <= 1'b1;
                end
                if (raise) begin
                    pend <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/cons_tx_out.sv
// Transmit side: registers the written byte and a one-cycle valid strobe.
// Assumes the consumer always accepts; the transmitter never reports busy.
module cons_tx_out #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    output logic          vld,
    output logic [DW-1:0] data
);
    // Present each written byte for exactly one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld  <= 1'b0;
            data <= '0;
        end else begin
            vld <= wr;
            if (wr) begin
                data <= wdata;
            end
        end
    end
endmodule

// File: rtl/console_uart.sv
// Console serial port top: control register, status assembly, read mux and
// interrupt acknowledge answer. Only the interrupt-enable control fields are kept.
module console_uart
    import cons_pkg::*;
#(
    parameter int          ADDR_W    = 2,
    parameter int          LVL_W     = 3,
    parameter int unsigned IRQ_LEVEL = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              char_in_vld,
    input  logic [DATA_W-1:0] char_in,
    output logic              char_out_vld,
    output logic [DATA_W-1:0] char_out,
    output logic              irq_req,
    input  logic              ack_valid,
    input  logic [LVL_W-1:0]  ack_level,
    output logic              ack_autovec
);
    localparam logic [LVL_W-1:0] LVL_CODE = LVL_W'(IRQ_LEVEL);

    cons_acc_t         acc;
    logic              rxie;
    logic [1:0]        txsel;
    logic              txie;
    logic              rx_full;
    logic [DATA_W-1:0] rx_held;
    logic              rx_pend;
    logic              tx_kick;
    logic [DATA_W-1:0] status;

    cons_bus_dec #(.ADDR_W(ADDR_W)) u_dec (
        .sel (bus_sel),
        .rd  (bus_rd),
        .wr  (bus_wr),
        .addr(bus_addr),
        .acc (acc)
    );

    // Control register: keep only the receive and transmit interrupt enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rxie  <= 1'b0;
            txsel <= 2'b00;
        end else if (acc.ctl_wr) begin
            rxie  <= bus_wdata[CTL_RXIE];
            txsel <= bus_wdata[CTL_TX_HI:CTL_TX_LO];
        end
    end

    // Transmit interrupts are on only for the one selector code.
    always_comb txie = (txsel == TXIE_CODE);

    cons_rx_buf #(.DW(DATA_W)) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .in_vld (char_in_vld),
        .in_data(char_in),
        .take   (acc.data_rd),
        .full   (rx_full),
        .held   (rx_held)
    );

    cons_irq_ctl u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .full   (rx_full),
        .rxie   (rxie),
        .txie   (txie),
        .data_rd(acc.data_rd),
        .data_wr(acc.data_wr),
        .irq    (irq_req),
        .pend   (rx_pend),
        .kick   (tx_kick)
    );

    cons_tx_out #(.DW(DATA_W)) u_tx (
        .clk  (clk),
        .rst_n(rst_n),
        .wr   (acc.data_wr),
        .wdata(bus_wdata),
        .vld  (char_out_vld),
        .data (char_out)
    );

    // Assemble the status byte from the live flags.
    always_comb begin
        status          = '0;
        status[ST_RXF]  = rx_full;
        status[ST_TXE]  = 1'b1;
        status[ST_PEND] = rx_pend;
    end

    // Read mux: status, held character, or all-ones for an empty buffer.
    always_comb begin
        if (acc.stat_rd) begin
            bus_rdata = status;
        end else if (acc.data_rd) begin
            bus_rdata = rx_full ? rx_held : '1;
        end else begin
            bus_rdata = '0;
        end
    end

    // Answer an acknowledge at this port's level with the autovector.
    always_comb ack_autovec = ack_valid && (ack_level == LVL_CODE);
endmodule

// File: rtl/console_uart_chk.sv
// Checker for the console port, attached by bind. Observes ports and the
// buffer/pending/kick state driven by separate submodules.
module console_uart_chk #(
    parameter int          ADDR_W    = 2,
    parameter int          LVL_W     = 3,
    parameter int unsigned IRQ_LEVEL = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic [7:0]        bus_rdata,
    input logic              char_out_vld,
    input logic [7:0]        char_out,
    input logic              irq_req,
    input logic              ack_valid,
    input logic [LVL_W-1:0]  ack_level,
    input logic              ack_autovec,
    input logic              rx_full,
    input logic [7:0]        rx_held,
    input logic              rx_pend,
    input logic              tx_kick,
    input logic              txie
);
    logic s_rd, d_rd, d_wr;
    always_comb begin
        s_rd = bus_sel && bus_rd && (bus_addr == ADDR_W'(0));
        d_rd = bus_sel && bus_rd && (bus_addr == ADDR_W'(2));
        d_wr = bus_sel && bus_wr && (bus_addr == ADDR_W'(2));
    end

    p_txe_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        s_rd |-> (bus_rdata[1] && bus_rdata[6:2] == 5'd0));

    p_pend_needs_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pend |-> rx_full);

    p_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        d_rd |=> (!rx_full && !rx_pend && !irq_req));

    p_empty_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (d_rd && !rx_full) |-> (bus_rdata == 8'hFF));

    p_no_overwrite_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && !d_rd) |=> $stable(rx_held));

    p_tx_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        d_wr |=> (char_out_vld && char_out == $past(bus_wdata)));

    p_tx_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !d_wr |=> !char_out_vld);

    p_tx_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (d_wr && txie && !d_rd) |=> !irq_req);

    p_tx_reraise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_kick && !d_rd && !(d_wr && txie)) |=> irq_req);

    p_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ack_autovec == (ack_valid && ack_level == LVL_W'(IRQ_LEVEL)));
endmodule

bind console_uart console_uart_chk #(
    .ADDR_W(ADDR_W), .LVL_W(LVL_W), .IRQ_LEVEL(IRQ_LEVEL)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .char_out_vld(char_out_vld), .char_out(char_out), .irq_req(irq_req),
    .ack_valid(ack_valid), .ack_level(ack_level), .ack_autovec(ack_autovec),
    .rx_full(rx_full), .rx_held(rx_held), .rx_pend(rx_pend), .tx_kick(tx_kick),
    .txie(txie)
);

// File: tb/tb_console_uart.sv
// Scoreboard bench: the write driver queues expected output characters and a
// monitor pops and compares them; register reads are compared in the driver.
module tb_console_uart;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       bus_sel, bus_rd, bus_wr;
    logic [1:0] bus_addr;
    logic [7:0] bus_wdata, bus_rdata;
    logic       char_in_vld;
    logic [7:0] char_in;
    logic       char_out_vld;
    logic [7:0] char_out;
    logic       irq_req;
    logic       ack_valid;
    logic [2:0] ack_level;
    logic       ack_autovec;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_q[$];

    always #5 clk = ~clk;

    console_uart dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .char_in_vld(char_in_vld), .char_in(char_in), .char_out_vld(char_out_vld),
        .char_out(char_out), .irq_req(irq_req), .ack_valid(ack_valid),
        .ack_level(ack_level), .ack_autovec(ack_autovec)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        step();
        bus_sel = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        if (a == 2'd2) exp_q.push_back(d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic send(input logic [7:0] c);
        char_in_vld = 1'b1; char_in = c;
        step();
        char_in_vld = 1'b0;
    endtask

    // Monitor: every output strobe must match the next queued character (R8).
    always @(negedge clk) begin
        if (rst_n === 1'b1 && char_out_vld === 1'b1) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R8: actual char %02h expected none", char_out);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                if (char_out !== e) begin
                    errors++;
                    $display("FAIL R8: actual char %02h expected %02h", char_out, e);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #1000000;
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] d;
        rst_n = 1'b0; bus_sel = 0; bus_rd = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
        char_in_vld = 0; char_in = 0; ack_valid = 0; ack_level = 0;
        repeat (3) step();
        rst_n = 1'b1;

        // R1: reset state
        chk("R1 irq", {7'd0, irq_req}, 8'h00);
        chk("R1 outvld", {7'd0, char_out_vld}, 8'h00);
        rd(2'd0, d); chk("R1 status", d, 8'h02);

        // R6: empty data read
        rd(2'd2, d); chk("R6 empty read", d, 8'hFF);
        rd(2'd0, d); chk("R6 status kept", d, 8'h02);

        // R2: control write does not alter status
        wr(2'd0, 8'h1C);
        rd(2'd0, d); chk("R2 status after ctl write", d, 8'h02);

        // R3, R11: capture with receive interrupts off
        send(8'h41);
        rd(2'd0, d); chk("R3 full next cycle", d, 8'h03);
        step(); step();
        rd(2'd0, d); chk("R11 no pending", d, 8'h03);
        chk("R11 irq low", {7'd0, irq_req}, 8'h00);
        rd(2'd2, d); chk("R5 data", d, 8'h41);
        rd(2'd0, d); chk("R5 cleared", d, 8'h02);

        // R7: overflow dropped
        send(8'h55);
        send(8'h66);
        rd(2'd2, d); chk("R7 kept first", d, 8'h55);
        rd(2'd0, d); chk("R7 empty after", d, 8'h02);

        // R4: receive interrupt
        wr(2'd0, 8'h80);
        send(8'h5A);
        rd(2'd0, d); chk("R4 bit7 not yet", d, 8'h03);
        chk("R4 irq up", {7'd0, irq_req}, 8'h01);
        rd(2'd0, d); chk("R4 pending", d, 8'h83);
        step(); step();
        chk("R4 irq held", {7'd0, irq_req}, 8'h01);
        rd(2'd2, d); chk("R5 data with irq", d, 8'h5A);
        chk("R5 irq dropped", {7'd0, irq_req}, 8'h00);
        rd(2'd0, d); chk("R5 status cleared", d, 8'h02);
        step();
        chk("R4 no re-raise when empty", {7'd0, irq_req}, 8'h00);

        // R8: transmit strobe
        wr(2'd0, 8'h00);
        wr(2'd2, 8'hC3);
        chk("R8 strobe high", {7'd0, char_out_vld}, 8'h01);
        step();
        chk("R8 strobe one cycle", {7'd0, char_out_vld}, 8'h00);

        // R9: transmit interrupt drop then re-raise
        wr(2'd0, 8'h20);
        wr(2'd2, 8'h31);
        chk("R9 low at write", {7'd0, irq_req}, 8'h00);
        step();
        chk("R9 raised", {7'd0, irq_req}, 8'h01);
        wr(2'd2, 8'h32);
        chk("R9 withdrawn", {7'd0, irq_req}, 8'h00);
        step();
        chk("R9 reasserted", {7'd0, irq_req}, 8'h01);
        rd(2'd2, d); chk("R6 read clears irq", {7'd0, irq_req}, 8'h00);
        wr(2'd0, 8'h60);
        wr(2'd2, 8'h33);
        step();
        chk("R9 code 11 no irq", {7'd0, irq_req}, 8'h00);
        wr(2'd0, 8'h40);
        wr(2'd2, 8'h34);
        step();
        chk("R9 code 10 no irq", {7'd0, irq_req}, 8'h00);

        // R12: odd offsets ignored
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h80);
        wr(2'd3, 8'h77);
        send(8'h12);
        step(); step();
        chk("R12 ctl untouched", {7'd0, irq_req}, 8'h00);
        rd(2'd3, d);
        rd(2'd1, d);
        rd(2'd0, d); chk("R12 status kept", d, 8'h03);
        rd(2'd2, d); chk("R12 data kept", d, 8'h12);

        // R10: acknowledge answer
        ack_valid = 1'b1; ack_level = 3'd5; #1;
        chk("R10 own level", {7'd0, ack_autovec}, 8'h01);
        ack_level = 3'd4; #1;
        chk("R10 other level", {7'd0, ack_autovec}, 8'h00);
        ack_valid = 1'b0; ack_level = 3'd5; #1;
        chk("R10 no ack", {7'd0, ack_autovec}, 8'h00);

        step(); step();
        chk("R8 queue drained", 8'(exp_q.size()), 8'h00);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule